// File: doc/BRIEF.md
# Address-Triggered Load/Store Register File

This block holds three banks of eight registers each: address registers (18 bits), index registers (18 bits) and operand registers (60 bits). Every bank has two combinational read ports and one write port. No load or store commands exist. A memory access starts when software writes an address register. Writing address register 1 to 5 fetches the word at the new address into the operand register with the same number. Writing address register 6 or 7 stores operand register 6 or 7 to the new address. Writing address register 0 has no side effect. An address is 18 bits, so the reachable memory is 262,144 words.

Accepted accesses go into an internal request queue and leave it in issue order. The queue drives a single-word memory request port with a valid/ready handshake. Read data comes back on a response port, tagged with the destination register number. While a load is outstanding, its operand register is marked pending. A read of a pending register raises a stall output. An address write that would overfill the queue, or that would start a second load into a register that is already pending, is refused: the block raises a busy signal and discards the write.

Top module: `addr_trig_regfile`

## Requirements
- R1: After reset, every register in all three banks reads zero, no operand register is pending, and `mem_req_valid` is low.
- R2: Read ports return the current register contents in the same cycle. A write to an index or operand register is visible from the next cycle. Index register 0 always reads zero, and writes to it are discarded.
- R3: An accepted write of value V to address register n, with n from 1 to 5, updates that register and queues a load (`mem_req_write`=0, address V, tag n).
- R4: An accepted write to address register 6 or 7 queues a store (`mem_req_write`=1, tag 6 or 7). The store data is the operand register's value before that clock edge. A direct operand write in the same cycle does not reach the store.
- R5: A write to address register 0 updates it, queues no request and never raises `a_wr_stall`.
- R6: `mem_req_valid` is high exactly when the queue is non-empty. The first queued request appears one cycle after its address write. Requests leave in issue order, one per cycle where valid and ready are both high, and the head is held unchanged while ready is low.
- R7: An operand register becomes pending in the cycle after its load is accepted and stops being pending after its response. `x_rd_stall` is high when an enabled operand read port addresses a pending register.
- R8: A response with tag t writes its data into operand register t, visible next cycle. It overrides a direct write to the same register in the same cycle. It also replaces any direct write made while the load was pending.
- R9: `a_wr_stall` is high for a write to address registers 1 to 7 while the queue holds `QDEPTH` entries, or for a write to 1 to 5 whose operand register is pending. A stalled write changes no register and queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_rd_idx0 | input | 3 | Address bank read port 0 index |
| a_rd_idx1 | input | 3 | Address bank read port 1 index |
| a_rd_data0 | output | 18 | Address bank read port 0 data |
| a_rd_data1 | output | 18 | Address bank read port 1 data |
| b_rd_idx0 | input | 3 | Index bank read port 0 index |
| b_rd_idx1 | input | 3 | Index bank read port 1 index |
| b_rd_data0 | output | 18 | Index bank read port 0 data |
| b_rd_data1 | output | 18 | Index bank read port 1 data |
| x_rd_en0 | input | 1 | Operand read port 0 in use |
| x_rd_idx0 | input | 3 | Operand read port 0 index |
| x_rd_en1 | input | 1 | Operand read port 1 in use |
| x_rd_idx1 | input | 3 | Operand read port 1 index |
| x_rd_data0 | output | 60 | Operand read port 0 data |
| x_rd_data1 | output | 60 | Operand read port 1 data |
| x_rd_stall | output | 1 | An enabled operand read targets a pending register |
| a_wr_en | input | 1 | Address bank write enable |
| a_wr_idx | input | 3 | Address bank write index |
| a_wr_data | input | 18 | Address bank write value |
| a_wr_stall | output | 1 | Current address write is refused |
| b_wr_en | input | 1 | Index bank write enable |
| b_wr_idx | input | 3 | Index bank write index |
| b_wr_data | input | 18 | Index bank write value |
| x_wr_en | input | 1 | Operand bank direct write enable |
| x_wr_idx | input | 3 | Operand bank direct write index |
| x_wr_data | input | 60 | Operand bank direct write value |
| mem_req_valid | output | 1 | Head request is valid |
| mem_req_ready | input | 1 | Memory accepts the head request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | 18 | Word address |
| mem_req_wdata | output | 60 | Store data |
| mem_req_tag | output | 3 | Register number of the access |
| mem_rsp_valid | input | 1 | Load data returning |
| mem_rsp_tag | input | 3 | Destination operand register |
| mem_rsp_data | input | 60 | Returned word |

## Verification
Two pairs of functions can land in the same cycle. A load response and a direct write can target the same operand register, and a store-triggering address write can coincide with a direct write to the operand register being stored. Directed steps force each collision. The bench then checks that the register holds the returned word, and that the store carries the value from before the edge. Random traffic with a randomly throttled ready and out-of-order responses produces the same overlaps many more times. Each outcome is compared with a bench model that applies the direct write first and the response second, and that snapshots the operand register before any update.

// File: rtl/atrf_pkg.sv
package atrf_pkg;
    localparam int ADDR_W    = 18;
    localparam int DATA_W    = 60;
    localparam int NREG      = 8;
    localparam int IDX_W     = $clog2(NREG);
    localparam int LOAD_LAST = 5;   // address registers 1..LOAD_LAST trigger loads, above trigger stores

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [IDX_W-1:0]  tag;
    } mem_req_t;
endpackage

// File: rtl/atrf_bank.sv
module atrf_bank
    import atrf_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter bit ZERO0 = 1'b0,
    parameter int NWR   = 1,
    parameter int NRD   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWR-1:0]   we,
    input  logic [IDX_W-1:0] widx  [NWR],
    input  logic [WIDTH-1:0] wdata [NWR],
    input  logic [IDX_W-1:0] ridx  [NRD],
    output logic [WIDTH-1:0] rdata [NRD]
);
    logic [WIDTH-1:0] regs_d [NREG];
    logic [WIDTH-1:0] regs_q [NREG];

    // later write ports take priority over earlier ones
    always_comb begin
        regs_d = regs_q;
        for (int w = 0; w < NWR; w++) begin
            if (we[w] && !(ZERO0 && widx[w] == '0)) begin
                regs_d[widx[w]] = wdata[w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        if (ZERO0) begin : g_zero
            assign rdata[p] = (ridx[p] == '0) ? '0 : regs_q[ridx[p]];
        end else begin : g_plain
            assign rdata[p] = regs_q[ridx[p]];
        end
    end
endmodule

// File: rtl/atrf_req_fifo.sv
module atrf_req_fifo
    import atrf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  mem_req_t push_data,
    input  logic     pop,
    output mem_req_t head,
    output logic     empty,
    output logic     full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t     s_d, s_q;
    mem_req_t slots_d [DEPTH];
    mem_req_t slots_q [DEPTH];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        slots_d = slots_q;
        if (push) begin
            slots_d[s_q.wr] = push_data;
            s_d.wr          = nxt(s_q.wr);
        end
        if (pop) begin
            s_d.rd = nxt(s_q.rd);
        end
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
        end else begin
            s_q     <= s_d;
            slots_q <= slots_d;
        end
    end

    assign head  = slots_q[s_q.rd];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CNT_W'(DEPTH));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_count_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
endmodule

// File: rtl/addr_trig_regfile.sv
module addr_trig_regfile
    import atrf_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_rd_idx0,
    input  logic [IDX_W-1:0]  a_rd_idx1,
    output logic [ADDR_W-1:0] a_rd_data0,
    output logic [ADDR_W-1:0] a_rd_data1,
    input  logic [IDX_W-1:0]  b_rd_idx0,
    input  logic [IDX_W-1:0]  b_rd_idx1,
    output logic [ADDR_W-1:0] b_rd_data0,
    output logic [ADDR_W-1:0] b_rd_data1,
    input  logic              x_rd_en0,
    input  logic [IDX_W-1:0]  x_rd_idx0,
    input  logic              x_rd_en1,
    input  logic [IDX_W-1:0]  x_rd_idx1,
    output logic [DATA_W-1:0] x_rd_data0,
    output logic [DATA_W-1:0] x_rd_data1,
    output logic              x_rd_stall,
    input  logic              a_wr_en,
    input  logic [IDX_W-1:0]  a_wr_idx,
    input  logic [ADDR_W-1:0] a_wr_data,
    output logic              a_wr_stall,
    input  logic              b_wr_en,
    input  logic [IDX_W-1:0]  b_wr_idx,
    input  logic [ADDR_W-1:0] b_wr_data,
    input  logic              x_wr_en,
    input  logic [IDX_W-1:0]  x_wr_idx,
    input  logic [DATA_W-1:0] x_wr_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [IDX_W-1:0]  mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic [IDX_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    typedef struct packed {
        logic [NREG-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    logic     q_full, q_empty, q_push, q_pop;
    mem_req_t q_in, q_head;
    logic     a_is_load, a_is_store, a_acc;

    logic [IDX_W-1:0]  a_ridx [2];
    logic [ADDR_W-1:0] a_rdat [2];
    logic [IDX_W-1:0]  b_ridx [2];
    logic [ADDR_W-1:0] b_rdat [2];
    logic [IDX_W-1:0]  x_ridx [3];
    logic [DATA_W-1:0] x_rdat [3];
    logic [IDX_W-1:0]  a_widx [1];
    logic [ADDR_W-1:0] a_wdat [1];
    logic [IDX_W-1:0]  b_widx [1];
    logic [ADDR_W-1:0] b_wdat [1];
    logic [IDX_W-1:0]  x_widx [2];
    logic [DATA_W-1:0] x_wdat [2];

    // access classification of the address write
    assign a_is_load  = (a_wr_idx != '0) && (a_wr_idx <= IDX_W'(LOAD_LAST));
    assign a_is_store = (a_wr_idx > IDX_W'(LOAD_LAST));
    assign a_wr_stall = a_wr_en && (a_wr_idx != '0) &&
                        (q_full || (a_is_load && st_q.pend[a_wr_idx]));
    assign a_acc      = a_wr_en && !a_wr_stall;

    // queue push carries the operand value held before this edge
    assign q_push      = a_acc && (a_is_load || a_is_store);
    assign q_in.write  = a_is_store;
    assign q_in.addr   = a_wr_data;
    assign q_in.wdata  = x_rdat[2];
    assign q_in.tag    = a_wr_idx;
    assign q_pop       = mem_req_valid && mem_req_ready;

    always_comb begin
        st_d = st_q;
        if (mem_rsp_valid) st_d.pend[mem_rsp_tag] = 1'b0;
        if (q_push && a_is_load) st_d.pend[a_wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_ridx[0] = a_rd_idx0;
    assign a_ridx[1] = a_rd_idx1;
    assign b_ridx[0] = b_rd_idx0;
    assign b_ridx[1] = b_rd_idx1;
    assign x_ridx[0] = x_rd_idx0;
    assign x_ridx[1] = x_rd_idx1;
    assign x_ridx[2] = a_wr_idx;
    assign a_widx[0] = a_wr_idx;
    assign a_wdat[0] = a_wr_data;
    assign b_widx[0] = b_wr_idx;
    assign b_wdat[0] = b_wr_data;
    // port 1 (returning load) wins over port 0 (direct write)
    assign x_widx[0] = x_wr_idx;
    assign x_wdat[0] = x_wr_data;
    assign x_widx[1] = mem_rsp_tag;
    assign x_wdat[1] = mem_rsp_data;

    atrf_bank #(.WIDTH(ADDR_W), .ZERO0(1'b0), .NWR(1), .NRD(2)) u_abank (
        .clk(clk), .rst_n(rst_n), .we(a_acc), .widx(a_widx), .wdata(a_wdat),
        .ridx(a_ridx), .rdata(a_rdat));

    atrf_bank #(.WIDTH(ADDR_W), .ZERO0(1'b1), .NWR(1), .NRD(2)) u_bbank (
        .clk(clk), .rst_n(rst_n), .we(b_wr_en), .widx(b_widx), .wdata(b_wdat),
        .ridx(b_ridx), .rdata(b_rdat));

    atrf_bank #(.WIDTH(DATA_W), .ZERO0(1'b0), .NWR(2), .NRD(3)) u_xbank (
        .clk(clk), .rst_n(rst_n), .we({mem_rsp_valid, x_wr_en}), .widx(x_widx),
        .wdata(x_wdat), .ridx(x_ridx), .rdata(x_rdat));

    atrf_req_fifo #(.DEPTH(QDEPTH)) u_reqq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(q_in), .pop(q_pop),
        .head(q_head), .empty(q_empty), .full(q_full));

    assign a_rd_data0    = a_rdat[0];
    assign a_rd_data1    = a_rdat[1];
    assign b_rd_data0    = b_rdat[0];
    assign b_rd_data1    = b_rdat[1];
    assign x_rd_data0    = x_rdat[0];
    assign x_rd_data1    = x_rdat[1];
    assign x_rd_stall    = (x_rd_en0 && st_q.pend[x_rd_idx0]) ||
                           (x_rd_en1 && st_q.pend[x_rd_idx1]);
    assign mem_req_valid = !q_empty;
    assign mem_req_write = q_head.write;
    assign mem_req_addr  = q_head.addr;
    assign mem_req_wdata = q_head.wdata;
    assign mem_req_tag   = q_head.tag;

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag)));
    p_load_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_acc && a_is_load) |=> st_q.pend[$past(a_wr_idx)]);
    p_rsp_expected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> st_q.pend[mem_rsp_tag]);
    p_store_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_tag > IDX_W'(LOAD_LAST)));
    p_a0_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_wr_idx == '0) |-> !a_wr_stall);
    p_load_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> (mem_req_tag != '0));
endmodule

// File: tb/addr_trig_regfile_tb_top.sv
module addr_trig_regfile_tb_top;
    localparam int QD = 4;

    typedef struct packed {
        bit        w;
        bit [17:0] addr;
        bit [59:0] d;
        bit [2:0]  tag;
    } req_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [2:0]  a_rd_idx0, a_rd_idx1, b_rd_idx0, b_rd_idx1, x_rd_idx0, x_rd_idx1;
    logic [17:0] a_rd_data0, a_rd_data1, b_rd_data0, b_rd_data1;
    logic [59:0] x_rd_data0, x_rd_data1;
    logic        x_rd_en0, x_rd_en1, x_rd_stall;
    logic        a_wr_en, b_wr_en, x_wr_en, a_wr_stall;
    logic [2:0]  a_wr_idx, b_wr_idx, x_wr_idx;
    logic [17:0] a_wr_data, b_wr_data;
    logic [59:0] x_wr_data;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [17:0] mem_req_addr;
    logic [59:0] mem_req_wdata;
    logic [2:0]  mem_req_tag;
    logic        mem_rsp_valid;
    logic [2:0]  mem_rsp_tag;
    logic [59:0] mem_rsp_data;

    addr_trig_regfile #(.QDEPTH(QD)) dut_i (.*);

    bit [17:0] ma [8];
    bit [17:0] mb [8];
    bit [59:0] mx [8];
    bit        pend [8];
    req_t      rq [$];
    int        sent [$];
    int        n_chk = 0;
    int        n_bad = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit [59:0] rnd60();
        return {$urandom(), $urandom()} & 60'hFFF_FFFF_FFFF_FFFF;
    endfunction

    task automatic idle();
        a_wr_en = 0; b_wr_en = 0; x_wr_en = 0; mem_rsp_valid = 0;
        x_rd_en0 = 0; x_rd_en1 = 0; mem_req_ready = 0;
    endtask

    task automatic respond_tag(input int t);
        for (int k = 0; k < sent.size(); k++) begin
            if (sent[k] == t) begin
                sent.delete(k);
                break;
            end
        end
        mem_rsp_valid = 1; mem_rsp_tag = 3'(t); mem_rsp_data = rnd60();
    endtask

    // check outputs before the edge, then advance the model across it
    task automatic cycle();
        bit        st_exp, a_st, acc, hs;
        bit [59:0] oldx [8];
        #1;
        chk("R3 a read0", a_rd_data0, ma[a_rd_idx0]);
        chk("R3 a read1", a_rd_data1, ma[a_rd_idx1]);
        chk("R2 b read0", b_rd_data0, (b_rd_idx0 == 0) ? 18'd0 : mb[b_rd_idx0]);
        chk("R2 b read1", b_rd_data1, (b_rd_idx1 == 0) ? 18'd0 : mb[b_rd_idx1]);
        chk("R8 x read0", x_rd_data0, mx[x_rd_idx0]);
        chk("R8 x read1", x_rd_data1, mx[x_rd_idx1]);
        st_exp = (x_rd_en0 && pend[x_rd_idx0]) || (x_rd_en1 && pend[x_rd_idx1]);
        chk("R7 stall", x_rd_stall, st_exp);
        a_st = a_wr_en && a_wr_idx != 0 &&
               (rq.size() == QD || (a_wr_idx <= 5 && pend[a_wr_idx]));
        chk("R9 a_wr_stall", a_wr_stall, a_st);
        chk("R6 req valid", mem_req_valid, rq.size() != 0);
        if (rq.size() != 0) begin
            chk("R6 req tag", mem_req_tag, rq[0].tag);
            chk("R3 req addr", mem_req_addr, rq[0].addr);
            chk("R4 req kind", mem_req_write, rq[0].w);
            if (rq[0].w) chk("R4 store data", mem_req_wdata, rq[0].d);
        end
        acc = a_wr_en && !a_st;
        hs  = (rq.size() != 0) && mem_req_ready;
        @(posedge clk);
        oldx = mx;
        if (hs) begin
            if (!rq[0].w) sent.push_back(rq[0].tag);
            void'(rq.pop_front());
        end
        if (acc) begin
            ma[a_wr_idx] = a_wr_data;
            if (a_wr_idx != 0) begin
                rq.push_back('{w: a_wr_idx > 5, addr: a_wr_data,
                               d: oldx[a_wr_idx], tag: a_wr_idx});
                if (a_wr_idx <= 5) pend[a_wr_idx] = 1;
            end
        end
        if (b_wr_en && b_wr_idx != 0) mb[b_wr_idx] = b_wr_data;
        if (x_wr_en) mx[x_wr_idx] = x_wr_data;
        if (mem_rsp_valid) begin
            mx[mem_rsp_tag]   = mem_rsp_data;
            pend[mem_rsp_tag] = 0;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        idle();
        a_rd_idx0 = 0; a_rd_idx1 = 0; b_rd_idx0 = 0; b_rd_idx1 = 0;
        x_rd_idx0 = 0; x_rd_idx1 = 0; a_wr_idx = 0; b_wr_idx = 0; x_wr_idx = 0;
        a_wr_data = 0; b_wr_data = 0; x_wr_data = 0; mem_rsp_tag = 0; mem_rsp_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state of every register and the request port
        for (int i = 0; i < 8; i++) begin
            a_rd_idx0 = 3'(i); b_rd_idx1 = 3'(i); x_rd_idx0 = 3'(i); x_rd_en0 = 1;
            #1;
            chk("R1 a reset", a_rd_data0, 0);
            chk("R1 b reset", b_rd_data1, 0);
            chk("R1 x reset", x_rd_data0, 0);
            chk("R1 no pending", x_rd_stall, 0);
            chk("R1 no request", mem_req_valid, 0);
            cycle();
        end
        idle();

        // R5: A0 write queues nothing
        a_wr_en = 1; a_wr_idx = 0; a_wr_data = 18'h2ABCD;
        cycle(); idle(); a_rd_idx0 = 0;
        #1 chk("R5 a0 no request", mem_req_valid, 0);
        cycle();

        // R2: B0 write discarded
        b_wr_en = 1; b_wr_idx = 0; b_wr_data = 18'h3FFFF;
        cycle(); idle(); b_rd_idx0 = 0;
        cycle();

        // R4: store snapshots X6 before a same-cycle direct write
        x_wr_en = 1; x_wr_idx = 6; x_wr_data = 60'h111_2222_3333_4444;
        cycle(); idle();
        x_wr_en = 1; x_wr_idx = 6; x_wr_data = 60'hAAA_BBBB_CCCC_DDDD;
        a_wr_en = 1; a_wr_idx = 6; a_wr_data = 18'h01234;
        cycle(); idle();
        #1 chk("R4 old X6 stored", mem_req_wdata, 60'h111_2222_3333_4444);
        mem_req_ready = 1;
        cycle(); idle();

        // R8: response and direct write to X3 in the same cycle
        a_wr_en = 1; a_wr_idx = 3; a_wr_data = 18'h00777;
        cycle(); idle();
        x_rd_en0 = 1; x_rd_idx0 = 3;
        #1 chk("R7 load pending stalls", x_rd_stall, 1);
        mem_req_ready = 1;
        cycle(); idle();
        respond_tag(3);
        x_wr_en = 1; x_wr_idx = 3; x_wr_data = 60'h0F0F_0F0F_0F0F_0F0;
        begin
            automatic bit [59:0] rd = mem_rsp_data;
            cycle(); idle();
            x_rd_idx0 = 3; x_rd_en0 = 1;
            #1 chk("R8 response wins", x_rd_data0, rd);
            chk("R7 pending cleared", x_rd_stall, 0);
        end
        cycle();

        // R9: fill the queue with stores, then one more is refused
        for (int i = 0; i < QD; i++) begin
            idle(); a_wr_en = 1; a_wr_idx = 3'(6 + (i % 2)); a_wr_data = 18'(100 + i);
            cycle();
        end
        idle(); a_wr_en = 1; a_wr_idx = 7; a_wr_data = 18'h3_0000; a_rd_idx1 = 7;
        #1 chk("R9 full stalls", a_wr_stall, 1);
        cycle(); idle();
        repeat (QD + 1) begin mem_req_ready = 1; cycle(); end
        idle();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            idle();
            a_rd_idx0 = 3'($urandom); a_rd_idx1 = 3'($urandom);
            b_rd_idx0 = 3'($urandom); b_rd_idx1 = 3'($urandom);
            x_rd_idx0 = 3'($urandom); x_rd_idx1 = 3'($urandom);
            x_rd_en0 = 1'($urandom); x_rd_en1 = 1'($urandom);
            a_wr_en = ($urandom % 3) == 0; a_wr_idx = 3'($urandom); a_wr_data = 18'($urandom);
            b_wr_en = 1'($urandom); b_wr_idx = 3'($urandom); b_wr_data = 18'($urandom);
            x_wr_en = ($urandom % 3) == 0; x_wr_idx = 3'($urandom); x_wr_data = rnd60();
            mem_req_ready = 1'($urandom);
            if (sent.size() != 0 && ($urandom % 3) == 0)
                respond_tag(sent[$urandom % sent.size()]);
            cycle();
        end

        summary();
        $finish;
    end
endmodule